// File: doc/BRIEF.md
# BAR Relocation Change Detector

This block sits beside a configuration register file. It watches dword writes that land on the base address registers and on the expansion ROM base register. When software moves a region to a new base, the block emits a single-cycle event. The event carries the previous base, the new base, the region length and the region type. Whatever performs the remapping uses that event. The block does no remapping itself.

The block holds its own copy of each region's last committed address, its encoded size and its kind. These are loaded through a small setup port at the time a region is registered. Sizing probes, values that do not change the decoded base, and writes narrower than a dword are all suppressed. A 64-bit memory region is reported only when its upper register is written. The two halves are then joined into 64-bit old and new bases.

Top module: `bar_move_watch`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `evt_valid` is 0. Every slot starts with kind code 3 (no region).
- R2: Only writes with `wr_be` equal to 4'hF are examined. Any other byte-enable pattern never raises an event and leaves the stored addresses unchanged.
- R3: A write of 32'hFFFFFFFF to a base register (register index FIRST_BAR to FIRST_BAR+NUM_BARS-1, slot = index minus FIRST_BAR) is a sizing probe. It raises no event and leaves the stored address unchanged.
- R4: For a slot of kind 0 (32-bit memory) or kind 1 (IO), a write whose value under `rf_wr_mask` equals the stored address under the same mask raises no event.
- R5: For a slot of kind 0 or 1, a masked change raises `evt_valid` for exactly one cycle, in the cycle after the write strobe. The event has old and new bases equal to the masked stored and written values (zero-extended), length equal to NOT(encoded size)+1 in 32 bits (zero-extended), and type equal to the slot's kind.
- R6: A write to the lower register of a 64-bit pair (slot kind 2) raises no event.
- R7: A write to the slot directly above a kind-2 slot is treated as the upper half. An event fires when either the masked upper value or the masked current lower register (`rf_lo_data` under `rf_lo_mask`) differs from its stored copy. The old base is {stored upper, stored lower} and the new base is {written value, current lower}, each half under its own mask. The length is NOT({upper size, lower size})+1 and the type is 2.
- R8: After an event the stored address of the written slot becomes the written value. For a 64-bit pair the lower slot also takes `rf_lo_data`, so repeating the same write raises no event.
- R9: A write to register ROM_IDX (slot NUM_BARS) raises an event only if that slot holds a region, bits 31:11 of the value are not all ones, and the masked value differs from the stored one. Such an event reports type 0.
- R10: Writes to registers outside the base and ROM registers, and writes to a slot of kind 3 that does not sit above a kind-2 slot, raise no event.
- R11: A `cfg_load` pulse sets the slot's stored address, encoded size and kind. Later writes are judged against these values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load one slot's region description |
| cfg_slot | input | $clog2(NUM_BARS+1) | Slot to load (NUM_BARS = ROM slot) |
| cfg_kind | input | 2 | 0 mem32, 1 IO, 2 mem64 lower, 3 none or upper half |
| cfg_addr | input | 32 | Initial register value of the slot |
| cfg_size | input | 32 | Encoded size, NOT(size-1) for this half |
| wr_valid | input | 1 | Configuration write strobe |
| wr_idx | input | IDX_W | Dword register index of the write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rf_wr_mask | input | 32 | Writable mask of the written register |
| rf_lo_data | input | 32 | Current contents of the register below the written one |
| rf_lo_mask | input | 32 | Writable mask of the register below the written one |
| evt_valid | output | 1 | One-cycle relocation event |
| evt_old | output | 64 | Previous base address |
| evt_new | output | 64 | New base address |
| evt_len | output | 64 | Region length in bytes |
| evt_type | output | 2 | Region type (0 mem32, 1 IO, 2 mem64) |

## Verification
The assertions take two things for granted. First, `cfg_load` and a write to the same slot never fall in the same cycle. Second, the mask and lower-register inputs reflect the register file as it stands before the write. The bench keeps its own register file model with per-register writable masks and drives `rf_wr_mask`, `rf_lo_data` and `rf_lo_mask` from it. Setup loads are issued only in cycles with no write pending. The random phase draws register indices from a range that always has a lower neighbour. It mixes probes, repeated values, partial byte enables and fresh values.

// File: rtl/bar_move_watch.sv
module bar_move_watch #(
  parameter int NUM_BARS = 6,
  parameter int IDX_W = 10,
  parameter int FIRST_BAR = 4,
  parameter int ROM_IDX = 12,
  parameter logic [31:0] ROM_PROBE_MASK = 32'hFFFF_F800
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_load,
  input  logic [$clog2(NUM_BARS+1)-1:0]   cfg_slot,
  input  logic [1:0]                      cfg_kind,
  input  logic [31:0]                     cfg_addr,
  input  logic [31:0]                     cfg_size,
  input  logic                            wr_valid,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [3:0]                      wr_be,
  input  logic [31:0]                     wr_data,
  input  logic [31:0]                     rf_wr_mask,
  input  logic [31:0]                     rf_lo_data,
  input  logic [31:0]                     rf_lo_mask,
  output logic                            evt_valid,
  output logic [63:0]                     evt_old,
  output logic [63:0]                     evt_new,
  output logic [63:0]                     evt_len,
  output logic [1:0]                      evt_type
);
  localparam int SLOTS = NUM_BARS + 1;
  localparam int SW = $clog2(SLOTS);
  localparam logic [1:0] K_MEM32 = 2'd0;
  localparam logic [1:0] K_IO    = 2'd1;
  localparam logic [1:0] K_MEM64 = 2'd2;
  localparam logic [1:0] K_NONE  = 2'd3;

  logic [31:0] st_addr [SLOTS];
  logic [31:0] st_size [SLOTS];
  logic [1:0]  st_kind [SLOTS];

  wire full_wr = wr_valid && (wr_be == 4'hF);
  wire in_bar  = (wr_idx >= IDX_W'(FIRST_BAR)) && (wr_idx < IDX_W'(FIRST_BAR + NUM_BARS));
  wire in_rom  = (wr_idx == IDX_W'(ROM_IDX));

  wire [SW-1:0] bar_slot = SW'(wr_idx - IDX_W'(FIRST_BAR));
  wire [SW-1:0] slot     = in_rom ? SW'(NUM_BARS) : (in_bar ? bar_slot : '0);
  wire [SW-1:0] lo_slot  = (slot == '0) ? '0 : slot - SW'(1);

  wire [1:0]  cur_kind = st_kind[slot];
  wire [1:0]  lo_kind  = st_kind[lo_slot];
  wire [31:0] nv  = wr_data & rf_wr_mask;
  wire [31:0] ov  = st_addr[slot] & rf_wr_mask;
  wire [31:0] nlo = rf_lo_data & rf_lo_mask;
  wire [31:0] olo = st_addr[lo_slot] & rf_lo_mask;

  wire probe     = (wr_data == 32'hFFFF_FFFF);
  wire rom_probe = ((wr_data & ROM_PROBE_MASK) == ROM_PROBE_MASK);

  wire hit32  = full_wr && in_bar && !probe &&
                (cur_kind == K_MEM32 || cur_kind == K_IO) && (nv != ov);
  wire hit64  = full_wr && in_bar && !probe && (cur_kind == K_NONE) &&
                (slot != '0) && (lo_kind == K_MEM64) && ((nv != ov) || (nlo != olo));
  wire hitrom = full_wr && in_rom && !rom_probe && (cur_kind != K_NONE) && (nv != ov);

  wire [31:0] len32 = ~st_size[slot] + 32'd1;
  wire [63:0] len64 = ~{st_size[slot], st_size[lo_slot]} + 64'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid <= 1'b0;
      evt_old   <= '0;
      evt_new   <= '0;
      evt_len   <= '0;
      evt_type  <= K_MEM32;
      for (int i = 0; i < SLOTS; i++) begin
        st_addr[i] <= '0;
        st_size[i] <= '0;
        st_kind[i] <= K_NONE;
      end
    end else begin
      evt_valid <= hit32 || hit64 || hitrom;
      if (hit32 || hitrom) begin
        evt_old  <= {32'd0, ov};
        evt_new  <= {32'd0, nv};
        evt_len  <= {32'd0, len32};
        evt_type <= hitrom ? K_MEM32 : cur_kind;
        st_addr[slot] <= wr_data;
      end else if (hit64) begin
        evt_old  <= {ov, olo};
        evt_new  <= {nv, nlo};
        evt_len  <= len64;
        evt_type <= K_MEM64;
        st_addr[slot]    <= wr_data;
        st_addr[lo_slot] <= rf_lo_data;
      end
      if (cfg_load && (int'(cfg_slot) < SLOTS)) begin
        st_addr[cfg_slot] <= cfg_addr;
        st_size[cfg_slot] <= cfg_size;
        st_kind[cfg_slot] <= cfg_kind;
      end
    end
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> !evt_valid);

  // R2
  full_only_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> $past(wr_valid && wr_be == 4'hF));

  // R3
  probe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && in_bar && wr_data == 32'hFFFF_FFFF) |=> !evt_valid);

  // R5
  moved_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (evt_old != evt_new) && (evt_type != K_NONE));

  // R9
  rom_probe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && in_rom && rom_probe) |=> !evt_valid);

  // R9
  rom_type_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && $past(in_rom)) |-> (evt_type == K_MEM32));

  // R10
  outside_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !in_bar && !in_rom) |=> !evt_valid);
endmodule

// File: tb/bar_move_watch_bench.sv
module bar_move_watch_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0;
  logic [2:0] cfg_slot = '0;
  logic [1:0] cfg_kind = '0;
  logic [31:0] cfg_addr = '0, cfg_size = '0;
  logic wr_valid = 1'b0;
  logic [9:0] wr_idx = '0;
  logic [3:0] wr_be = '0;
  logic [31:0] wr_data = '0, rf_wr_mask = '0, rf_lo_data = '0, rf_lo_mask = '0;
  logic evt_valid;
  logic [63:0] evt_old, evt_new, evt_len;
  logic [1:0] evt_type;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_addr [7];
  logic [31:0] m_size [7];
  logic [1:0]  m_kind [7];
  logic [31:0] rf  [16];
  logic [31:0] msk [16];

  always #2 clk = ~clk;

  bar_move_watch u_bar_move_watch (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_slot(cfg_slot), .cfg_kind(cfg_kind),
    .cfg_addr(cfg_addr), .cfg_size(cfg_size), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_be(wr_be), .wr_data(wr_data), .rf_wr_mask(rf_wr_mask), .rf_lo_data(rf_lo_data),
    .rf_lo_mask(rf_lo_mask), .evt_valid(evt_valid), .evt_old(evt_old), .evt_new(evt_new),
    .evt_len(evt_len), .evt_type(evt_type));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int slot_of(input int idx);
    if (idx >= 4 && idx < 10) return idx - 4;
    if (idx == 12) return 6;
    return -1;
  endfunction

  // Prediction from the requirements, then model update.
  logic        g_ev;
  logic [63:0] g_old, g_new, g_len;
  logic [1:0]  g_typ;

  task automatic predict(input int idx, input logic [3:0] be, input logic [31:0] v);
    int s;
    logic [31:0] m, nv, ov, lm, nlo, olo, wm;
    s = slot_of(idx);
    g_ev = 0; g_old = 0; g_new = 0; g_len = 0; g_typ = 0;
    m = msk[idx]; nv = v & m; ov = (s >= 0) ? (m_addr[s] & m) : 0;
    if (be == 4'hF && s == 6) begin
      if (m_kind[6] != 2'd3 && (v & 32'hFFFF_F800) != 32'hFFFF_F800 && nv != ov) begin
        g_ev = 1; g_old = {32'd0, ov}; g_new = {32'd0, nv};
        g_len = {32'd0, ~m_size[6] + 32'd1}; g_typ = 2'd0; m_addr[6] = v;
      end
    end else if (be == 4'hF && s >= 0 && v != 32'hFFFF_FFFF) begin
      if ((m_kind[s] == 2'd0 || m_kind[s] == 2'd1) && nv != ov) begin
        g_ev = 1; g_old = {32'd0, ov}; g_new = {32'd0, nv};
        g_len = {32'd0, ~m_size[s] + 32'd1}; g_typ = m_kind[s]; m_addr[s] = v;
      end else if (m_kind[s] == 2'd3 && s > 0 && m_kind[s-1] == 2'd2) begin
        lm = msk[idx-1]; nlo = rf[idx-1] & lm; olo = m_addr[s-1] & lm;
        if (nv != ov || nlo != olo) begin
          g_ev = 1; g_old = {ov, olo}; g_new = {nv, nlo};
          g_len = ~{m_size[s], m_size[s-1]} + 64'd1; g_typ = 2'd2;
          m_addr[s] = v; m_addr[s-1] = rf[idx-1];
        end
      end
    end
    if (be == 4'hF) begin
      wm = m;
      if (s >= 0 && s < 6 && v == 32'hFFFF_FFFF) wm = wm & m_size[s];
      if (s == 6 && (v & 32'hFFFF_F800) == 32'hFFFF_F800) wm = wm & m_size[6];
      rf[idx] = (rf[idx] & ~m) | (v & wm);
    end else begin
      for (int b = 0; b < 4; b++)
        if (be[b]) begin
          wm = (32'hFF << (8*b)) & m;
          rf[idx] = (rf[idx] & ~wm) | (v & wm);
        end
    end
  endtask

  task automatic wr(input int idx, input logic [3:0] be, input logic [31:0] v, input string tag);
    @(negedge clk);
    wr_valid = 1; wr_idx = 10'(idx); wr_be = be; wr_data = v;
    rf_wr_mask = msk[idx]; rf_lo_data = rf[idx-1]; rf_lo_mask = msk[idx-1];
    predict(idx, be, v);
    @(negedge clk);
    wr_valid = 0;
    chk({tag, " valid"}, {63'd0, evt_valid}, {63'd0, g_ev});
    if (g_ev) begin
      chk({tag, " old"}, evt_old, g_old);
      chk({tag, " new"}, evt_new, g_new);
      chk({tag, " len"}, evt_len, g_len);
      chk({tag, " type"}, {62'd0, evt_type}, {62'd0, g_typ});
    end
  endtask

  task automatic lit(input string tag, input logic ev, input logic [63:0] o, input logic [63:0] n,
                     input logic [63:0] l, input logic [1:0] t);
    chk({tag, " lit valid"}, {63'd0, evt_valid}, {63'd0, ev});
    if (ev) begin
      chk({tag, " lit old"}, evt_old, o);
      chk({tag, " lit new"}, evt_new, n);
      chk({tag, " lit len"}, evt_len, l);
      chk({tag, " lit type"}, {62'd0, evt_type}, {62'd0, t});
    end
  endtask

  task automatic load(input int s, input logic [1:0] k, input logic [31:0] a, input logic [31:0] sz,
                      input logic [31:0] mk);
    @(negedge clk);
    cfg_load = 1; cfg_slot = 3'(s); cfg_kind = k; cfg_addr = a; cfg_size = sz;
    @(negedge clk);
    cfg_load = 0;
    m_addr[s] = a; m_size[s] = sz; m_kind[s] = k;
    if (s == 6) begin rf[12] = a; msk[12] = mk; end
    else begin rf[s+4] = a; msk[s+4] = mk; end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int idx, r;
    logic [3:0] be;
    logic [31:0] v;
    for (int i = 0; i < 7; i++) begin m_addr[i] = 0; m_size[i] = 0; m_kind[i] = 2'd3; end
    for (int i = 0; i < 16; i++) begin rf[i] = 0; msk[i] = 0; end
    msk[3] = 32'h0000_00FF; msk[13] = 32'hFFFF_FFFF;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 reset", {63'd0, evt_valid}, 64'd0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", {63'd0, evt_valid}, 64'd0);

    load(0, 2'd0, 32'hE000_0000, 32'hFFFF_F000, 32'hFFFF_FFF0);
    load(1, 2'd1, 32'h0000_C001, 32'hFFFF_FF00, 32'hFFFF_FFFC);
    load(2, 2'd2, 32'h8000_000C, 32'hFFFE_0000, 32'hFFFF_FFF0);
    load(3, 2'd3, 32'h0000_0040, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    load(6, 2'd0, 32'hF000_0000, 32'hFFFF_0000, 32'hFFFF_F800);

    wr(4, 4'hF, 32'hD000_0000, "R5 mem32 move");
    lit("R5", 1, 64'hE000_0000, 64'hD000_0000, 64'h1000, 2'd0);
    @(negedge clk);
    chk("R5 one-cycle pulse", {63'd0, evt_valid}, 64'd0);
    wr(4, 4'hF, 32'hD000_0005, "R4 masked same");
    lit("R4", 0, 0, 0, 0, 0);
    wr(4, 4'hF, 32'hFFFF_FFFF, "R3 probe");
    lit("R3", 0, 0, 0, 0, 0);
    wr(4, 4'hF, 32'hD000_0000, "R3 store kept");
    lit("R3 store kept", 0, 0, 0, 0, 0);
    wr(4, 4'h3, 32'h1234_5670, "R2 partial");
    lit("R2", 0, 0, 0, 0, 0);
    wr(4, 4'hF, 32'hD000_0000, "R2 store kept");
    lit("R2 store kept", 0, 0, 0, 0, 0);
    wr(5, 4'hF, 32'h0000_B001, "R5 io move");
    lit("R5 io", 1, 64'hC000, 64'hB000, 64'h100, 2'd1);
    wr(6, 4'hF, 32'hA000_000C, "R6 lower half");
    lit("R6", 0, 0, 0, 0, 0);
    wr(7, 4'hF, 32'h0000_0040, "R7 lower moved");
    lit("R7", 1, 64'h40_8000_0000, 64'h40_A000_0000, 64'h2_0000, 2'd2);
    wr(7, 4'hF, 32'h0000_0040, "R8 pair updated");
    lit("R8", 0, 0, 0, 0, 0);
    wr(7, 4'hF, 32'h0000_0041, "R7 upper moved");
    lit("R7 upper", 1, 64'h40_A000_0000, 64'h41_A000_0000, 64'h2_0000, 2'd2);
    wr(12, 4'hF, 32'hE000_0001, "R9 rom move");
    lit("R9", 1, 64'hF000_0000, 64'hE000_0000, 64'h1_0000, 2'd0);
    wr(12, 4'hF, 32'hFFFF_F800, "R9 rom probe");
    lit("R9 probe", 0, 0, 0, 0, 0);
    wr(8, 4'hF, 32'h0000_1234, "R10 empty slot");
    lit("R10 empty", 0, 0, 0, 0, 0);
    wr(3, 4'hF, 32'h5555_5555, "R10 outside");
    lit("R10 outside", 0, 0, 0, 0, 0);
    load(4, 2'd0, 32'h1000_0000, 32'hFFFF_F000, 32'hFFFF_FFF0);
    wr(8, 4'hF, 32'h2000_0000, "R11 loaded slot");
    lit("R11", 1, 64'h1000_0000, 64'h2000_0000, 64'h1000, 2'd0);

    for (int n = 0; n < 4000; n++) begin
      idx = 3 + int'($urandom % 11);
      be = ($urandom % 5 == 0) ? 4'($urandom) : 4'hF;
      r = int'($urandom % 6);
      case (r)
        0: v = 32'hFFFF_FFFF;
        1: v = rf[idx];
        2: v = rf[idx] ^ (32'h1 << ($urandom % 8));
        3: v = $urandom;
        4: v = 32'($urandom % 4) << 28;
        default: v = 32'hFFFF_F800 | 32'($urandom % 2048);
      endcase
      wr(idx, be, v, "R2-mix random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule